// File: doc/BRIEF.md
# Serial multiply-accumulate FIR filter

This block is a 16-tap FIR filter for signed 16-bit audio samples. It uses one multiplier and one accumulator, and it walks through the taps over successive clock cycles. When a sample is accepted, the block pushes it into its sample history. It then clears the accumulator and adds one sample-times-coefficient product per cycle. At the end it rounds the wide sum back to 16 bits and presents the result on a registered output with a one-cycle valid strobe.

The coefficients are fixed constants held inside the block. The source of the samples sends one sample per computation and waits for the result strobe. Any pulse on the input strobe while a computation is running is dropped, and the history is left untouched.

Top module: `fir_mac_serial`

## Requirements
- R1: A strobe on `in_valid` while the block is idle accepts `in_sample`. The sample becomes history position 0 (the newest), every older sample moves up one position, and the sample at position 15 is discarded.
- R2: Coefficient k is 131*(k+1)*(16-k) - 2000, so k=0 gives 96 and k=7 gives 7432. It multiplies history position k, and the sum runs over all 16 positions.
- R3: The sum is held in a 36-bit signed accumulator. For 16 full-scale samples of either sign, the accumulator does not wrap.
- R4: The output is floor(sum / 2^15) plus bit 14 of the sum. The output therefore rounds to nearest, with ties going upward, and is not truncated.
- R5: When the rounded value lies above 32767 or below -32768, the output is clamped to that limit.
- R6: `out_valid` goes high exactly 19 rising edges after the edge that accepted the sample, and it stays high for one cycle only.
- R7: `out_sample` changes only in a cycle where `out_valid` is high, and it holds its value between results.
- R8: `in_valid` pulses that arrive while a computation is in progress, including during its final store cycle, are ignored. They cause no shift and no extra output.
- R9: A synchronous reset (`rst` high) clears the output, the valid strobe and the whole sample history to zero.
- R10: The accumulator and the tap counter restart from zero for every accepted sample, so no part of an earlier sum carries into the next result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | 16 | Signed input sample |
| out_valid | output | 1 | One-cycle result strobe |
| out_sample | output | 16 | Signed filtered result, held until the next result |

## Verification
The bench creates sums whose bit 14 is set, so a design that truncates instead of rounding would come out one lower. It drives full-scale positive and full-scale negative runs. A design with too narrow an accumulator, or without the clamp, would wrap to the wrong sign there. It injects strobes during the load, clear, accumulate and store phases. A design that honours them would corrupt the history or emit an extra result. A reset in the middle of a run is followed by an impulse, which exposes any history that was left uncleared.

// File: rtl/fir_mac_serial.sv
module fir_mac_serial #(
  parameter int DATA_W = 16,
  parameter int TAPS   = 16,
  parameter int COEF_W = 16,
  parameter int ACC_W  = 36
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_sample,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_sample
);

  localparam int AW     = (TAPS > 1) ? $clog2(TAPS) : 1;
  localparam int PROD_W = DATA_W + COEF_W;
  localparam int FRAC   = COEF_W - 1;
  localparam logic [AW-1:0] LAST = AW'(TAPS - 1);
  localparam logic signed [ACC_W-1:0] ONE    = ACC_W'(1);
  localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'((64'sd1 <<< (DATA_W - 1)) - 64'sd1);
  localparam logic signed [ACC_W-1:0] SAT_LO = -SAT_HI - ONE;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_LOAD  = 3'd1,
    S_CLEAR = 3'd2,
    S_MAC   = 3'd3,
    S_STORE = 3'd4
  } phase_t;

  phase_t                          phase_q;
  logic [TAPS-1:0][DATA_W-1:0]     line_q;
  logic [TAPS-1:0][COEF_W-1:0]     coef_rom;
  logic signed [DATA_W-1:0]        hold_q;
  logic [AW-1:0]                   tap_q;
  logic signed [ACC_W-1:0]         acc_q;
  logic signed [DATA_W-1:0]        x_sel;
  logic signed [COEF_W-1:0]        c_sel;
  logic signed [PROD_W-1:0]        prod;
  logic signed [ACC_W-1:0]         kept;
  logic signed [ACC_W-1:0]         rnd;
  logic signed [DATA_W-1:0]        res;

  function automatic logic [COEF_W-1:0] coef_of(input int k);
    int v;
    v = 131 * (k + 1) * (TAPS - k) - 2000;
    return COEF_W'(v);
  endfunction

  generate
    for (genvar k = 0; k < TAPS; k++) begin : g_coef
      assign coef_rom[k] = coef_of(k);
    end
  endgenerate

  assign x_sel = $signed(line_q[tap_q]);
  assign c_sel = $signed(coef_rom[tap_q]);
  assign prod  = PROD_W'(x_sel) * PROD_W'(c_sel);

  assign kept = acc_q >>> FRAC;
  assign rnd  = acc_q[FRAC-1] ? kept + ONE : kept;
  assign res  = (rnd > SAT_HI) ? $signed(SAT_HI[DATA_W-1:0]) :
                (rnd < SAT_LO) ? $signed(SAT_LO[DATA_W-1:0]) :
                                 $signed(rnd[DATA_W-1:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q    <= S_IDLE;
      line_q     <= '0;
      hold_q     <= '0;
      tap_q      <= '0;
      acc_q      <= '0;
      out_valid  <= 1'b0;
      out_sample <= '0;
    end else begin
      out_valid <= 1'b0;
      unique case (phase_q)
        S_IDLE: begin
          if (in_valid) begin
            hold_q  <= in_sample;
            phase_q <= S_LOAD;
          end
        end
        S_LOAD: begin
          line_q  <= {line_q[TAPS-2:0], hold_q};
          phase_q <= S_CLEAR;
        end
        S_CLEAR: begin
          acc_q   <= '0;
          tap_q   <= '0;
          phase_q <= S_MAC;
        end
        S_MAC: begin
          acc_q <= acc_q + ACC_W'(prod);
          tap_q <= tap_q + 1'b1;
          if (tap_q == LAST) phase_q <= S_STORE;
        end
        S_STORE: begin
          out_sample <= res;
          out_valid  <= 1'b1;
          phase_q    <= S_IDLE;
        end
        default: phase_q <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fir_mac_serial_chk.sv
module fir_mac_serial_chk #(
  parameter int DATA_W = 16,
  parameter int TAPS   = 16,
  parameter int COEF_W = 16,
  parameter int ACC_W  = 36,
  parameter int AW     = 4
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        out_valid,
  input logic [DATA_W-1:0]           out_sample,
  input logic [2:0]                  phase,
  input logic [AW-1:0]               tap,
  input logic [ACC_W-1:0]            acc,
  input logic [TAPS-1:0][DATA_W-1:0] line
);

  localparam logic [2:0] P_IDLE  = 3'd0;
  localparam logic [2:0] P_LOAD  = 3'd1;
  localparam logic [2:0] P_CLEAR = 3'd2;
  localparam logic [2:0] P_MAC   = 3'd3;
  localparam logic [2:0] P_STORE = 3'd4;
  localparam logic [AW-1:0] LAST = AW'(TAPS - 1);

  assert_step_R2: assert property (@(posedge clk) disable iff (rst)
    (phase == P_MAC && tap != LAST) |=> tap == $past(tap) + 1'b1);

  assert_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  assert_from_store_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(phase) == P_STORE);

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !$stable(out_sample) |-> out_valid);

  assert_no_shift_R8: assert property (@(posedge clk) disable iff (rst)
    (phase != P_LOAD) |=> $stable(line));

  assert_busy_R8: assert property (@(posedge clk) disable iff (rst)
    (phase != P_IDLE) |=> phase != P_LOAD);

  assert_reset_R9: assert property (@(posedge clk)
    rst |=> (!out_valid && out_sample == '0 && line == '0));

  assert_clear_R10: assert property (@(posedge clk) disable iff (rst)
    (phase == P_CLEAR) |=> (acc == '0 && tap == '0));

endmodule

bind fir_mac_serial fir_mac_serial_chk #(
  .DATA_W(DATA_W), .TAPS(TAPS), .COEF_W(COEF_W), .ACC_W(ACC_W), .AW(AW)
) chk_i (
  .clk(clk), .rst(rst), .out_valid(out_valid), .out_sample(out_sample),
  .phase(phase_q), .tap(tap_q), .acc(acc_q), .line(line_q)
);

// File: tb/fir_mac_serial_tb_top.sv
module fir_mac_serial_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [15:0] in_sample = '0;
  logic out_valid;
  logic signed [15:0] out_sample;

  int total = 0;
  int bad = 0;
  int hist [16];
  int last_out = 0;

  always #4 clk = ~clk;

  fir_mac_serial dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .out_valid(out_valid), .out_sample(out_sample)
  );

  function automatic int coef(input int k);
    return 131 * (k + 1) * (16 - k) - 2000;
  endfunction

  function automatic int model_out();
    longint acc = 0;
    longint r;
    for (int k = 0; k < 16; k++) acc += longint'(hist[k]) * longint'(coef(k));
    r = acc >>> 15;
    if (acc[14]) r = r + 1;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return int'(r);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 16; k++) hist[k] = 0;
    last_out = 0;
    chk(out_valid == 1'b0, "R9", int'(out_valid), 0);
    chk(out_sample == 16'sd0, "R9", int'(out_sample), 0);
  endtask

  task automatic send(input int s, input string req, input int junk_at, input int junk);
    int exp;
    int cnt;
    int extra;
    bit seen;
    @(negedge clk);
    in_valid = 1'b1;
    in_sample = 16'(s);
    for (int k = 15; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = s;
    exp = model_out();
    @(negedge clk);
    in_valid = (junk_at == 0);
    in_sample = 16'(junk);
    cnt = 0;
    seen = 1'b0;
    while (!seen && cnt < 60) begin
      @(negedge clk);
      cnt++;
      if (out_valid) seen = 1'b1;
      else if (cnt == 10) chk(int'(out_sample) == last_out, "R7", int'(out_sample), last_out);
      in_valid = (cnt == junk_at);
      in_sample = 16'(junk);
    end
    in_valid = 1'b0;
    chk(seen && cnt == 19, "R6", cnt, 19);
    chk(int'(out_sample) == exp, req, int'(out_sample), exp);
    @(negedge clk);
    chk(out_valid == 1'b0, "R6", int'(out_valid), 0);
    if (junk_at >= 0) begin
      extra = 0;
      repeat (25) begin
        @(negedge clk);
        if (out_valid) extra++;
      end
      chk(extra == 0, "R8", extra, 0);
      chk(int'(out_sample) == exp, "R8", int'(out_sample), exp);
    end
    last_out = exp;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h00c0ffee));
    do_reset();
    // R4: 171*96 = 16416 has bit 14 set, rounds to 1 where truncation gives 0
    send(171, "R4", -1, 0);
    for (int i = 0; i < 15; i++) send(0, "R2", -1, 0);
    send(-171, "R4", -1, 0);
    for (int i = 0; i < 16; i++) send(32767, "R3", -1, 0);
    for (int i = 0; i < 16; i++) send(-32768, "R5", -1, 0);
    send(0, "R10", -1, 0);
    send(1000, "R1", 0, 12345);
    send(-2000, "R8", 1, -7777);
    send(3000, "R8", 9, 31000);
    send(-4000, "R8", 18, -31000);
    for (int i = 0; i < 40; i++) begin
      int s;
      s = int'($signed(16'($urandom())));
      send(s, "R4", -1, 0);
    end
    for (int i = 0; i < 8; i++) send(int'($urandom_range(0, 20000)) - 10000, "R10", -1, 0);
    do_reset();
    send(5000, "R9", -1, 0);
    send(0, "R9", -1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule